// File: doc/BRIEF.md
# Weighted Two-Level Channel Arbiter

This block decides which of several DMA channels may use a shared bus master port. Each channel has a request line, a one-bit priority level and a 4-bit weight. The arbiter gives out a one-hot grant and holds it until the granted channel pulses `done`, which ends that channel's tenure on the bus.

A requesting high-priority channel always wins over every low-priority channel. Inside the chosen level, each channel has a credit counter that is loaded from its weight. Each grant uses one credit. Channels that still have credit are served in round-robin order. When no requester in the level has credit left, the whole level reloads and a grant is made in the same cycle. Over time, bus tenures within a level are therefore shared in proportion to the weights.

The priority and weight inputs are static configuration. The channel count is a parameter.

Top module: `bw_share_arb`

## Requirements
- R1: While reset is asserted, and right after it is released, `grant` is all zeros.
- R2: `grant` always has at most one bit set.
- R3: A grant is issued one cycle after the arbiter sees `grant` idle, and only to a channel whose `req` bit was high in that decision cycle.
- R4: Once issued, a grant keeps its value in every cycle until `done` is sampled high, even if the requests change.
- R5: When `done` is sampled high while a grant is held, `grant` is zero in the next cycle. A new decision is made in the cycle after that.
- R6: If any requesting channel has `hi_prio` set (1 = high level), the grant goes to one of the high-level requesters.
- R7: Within a level, each channel gets a number of consecutive-window tenures equal to its weight, and the channels are served in round-robin order. The weight of channel i is in `weight[4i+3:4i]`. The search starts after the last granted index. After reset the last index is N_CH-1, so the search starts at channel 0.
- R8: When every requester in the chosen level has zero credit, all credits in that level reload from their weights in the same cycle as the grant. Credit held by a non-requesting channel does not block this reload, and a channel that does not request spends no credit.
- R9: A weight of 0 behaves exactly like a weight of 1.
- R10: With no requests, no grant is issued, and a `done` pulse while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N_CH | Per-channel bus request |
| hi_prio | input | N_CH | Per-channel level, 1 = high |
| weight | input | 4*N_CH | Per-channel weight, channel i at bits [4i+3:4i] |
| done | input | 1 | End of the current tenure |
| grant | output | N_CH | One-hot grant, zero when idle |

## Verification
A level reload and the credit debit of the winning channel can happen in the same cycle. The grant chosen in that cycle is picked as if every credit were already full. This case is provoked by keeping two unequal-weight channels requesting until both run dry. It is judged by the grant sequence that follows: the reload winner must appear once more, and the heavier channel must then take its full weight of tenures. A second overlap, a higher-priority request arriving while a low-level grant is still held, is checked by observing that the grant stays put until `done` and then moves to the high-level channel.

// File: rtl/bwarb_pkg.sv
package bwarb_pkg;
  localparam int WGT_W = 4;

  // zero weight is promoted to one
  function automatic logic [WGT_W-1:0] wgt_eff(input logic [WGT_W-1:0] w);
    return (w == '0) ? WGT_W'(1) : w;
  endfunction
endpackage

// File: rtl/bwarb_credit.sv
module bwarb_credit
  import bwarb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WGT_W-1:0] wgt,
  input  logic             reload,
  input  logic             take,
  output logic             has_cred
);
  logic [WGT_W-1:0] cred_q, cred_d;
  logic             upd;

  always_comb begin
    upd    = reload | take;
    cred_d = cred_q;
    if (reload)    cred_d = wgt_eff(wgt) - (take ? WGT_W'(1) : WGT_W'(0));
    else if (take) cred_d = cred_q - WGT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cred_q <= '0;
    else if (upd) cred_q <= cred_d;
  end

  assign has_cred = (cred_q != '0);
endmodule

// File: rtl/bwarb_pick.sv
module bwarb_pick #(
  parameter int N_CH  = 6,
  parameter int IDX_W = 3
) (
  input  logic [N_CH-1:0]  cand,
  input  logic [IDX_W-1:0] last,
  output logic [N_CH-1:0]  pick,
  output logic [IDX_W-1:0] pick_idx
);
  int   idx;
  logic found;

  always_comb begin
    pick     = '0;
    pick_idx = last;
    found    = 1'b0;
    idx      = 0;
    for (int off = 1; off <= N_CH; off++) begin
      idx = int'(last) + off;
      if (idx >= N_CH) idx = idx - N_CH;
      if (!found && cand[idx]) begin
        found     = 1'b1;
        pick[idx] = 1'b1;
        pick_idx  = IDX_W'(idx);
      end
    end
  end
endmodule

// File: rtl/bw_share_arb.sv
module bw_share_arb
  import bwarb_pkg::*;
#(
  parameter int N_CH = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CH-1:0]       req,
  input  logic [N_CH-1:0]       hi_prio,
  input  logic [N_CH*WGT_W-1:0] weight,
  input  logic                  done,
  output logic [N_CH-1:0]       grant
);
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [N_CH-1:0]  grant_q, grant_d;
  logic [IDX_W-1:0] last_q, pick_idx;
  logic [N_CH-1:0]  lvl_mask, lvl_req, has_cred, elig, cand, pick;
  logic             reload, decide, busy;

  // level choice and candidate set
  always_comb begin
    lvl_mask = (|(req & hi_prio)) ? hi_prio : ~hi_prio;
    lvl_req  = req & lvl_mask;
    elig     = lvl_req & has_cred;
    reload   = (elig == '0) && (lvl_req != '0);
    cand     = reload ? lvl_req : elig;
    busy     = (grant_q != '0);
    decide   = !busy && (lvl_req != '0);
  end

  bwarb_pick #(.N_CH(N_CH), .IDX_W(IDX_W)) u_pick (
    .cand     (cand),
    .last     (last_q),
    .pick     (pick),
    .pick_idx (pick_idx)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_cred
    bwarb_credit u_cred (
      .clk      (clk),
      .rst_n    (rst_n),
      .wgt      (weight[i*WGT_W +: WGT_W]),
      .reload   (decide & reload & lvl_mask[i]),
      .take     (decide & pick[i]),
      .has_cred (has_cred[i])
    );
  end

  always_comb begin
    grant_d = grant_q;
    if (busy) begin
      if (done) grant_d = '0;
    end else if (decide) begin
      grant_d = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      last_q  <= IDX_W'(N_CH - 1);
    end else begin
      grant_q <= grant_d;
      if (decide) last_q <= pick_idx;
    end
  end

  assign grant = grant_q;
endmodule

// File: rtl/bwarb_chk.sv
module bwarb_chk #(
  parameter int N_CH = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] req,
  input logic [N_CH-1:0] hi_prio,
  input logic            done,
  input logic [N_CH-1:0] grant
);
  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !done) |=> (grant == $past(grant)));

  // R5
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && done) |=> (grant == '0));

  // R3
  grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |=> (grant == '0 || (grant & $past(req)) != '0));

  // R6
  prio_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && (req & hi_prio) != '0) |=> ((grant & $past(hi_prio)) != '0));

  // R10
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && req == '0) |=> (grant == '0));
endmodule

bind bw_share_arb bwarb_chk #(.N_CH(N_CH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req     (req),
  .hi_prio (hi_prio),
  .done    (done),
  .grant   (grant)
);

// File: tb/bw_share_arb_bench.sv
module bw_share_arb_bench;
  localparam int N  = 6;
  localparam int NV = 5;
  localparam int NG = 8;

  // stimulus: requests, levels, weights; expected grant index sequence
  localparam logic [N-1:0]   V_REQ [NV] = '{6'b111111, 6'b000011, 6'b010010, 6'b001100, 6'b100101};
  localparam logic [N-1:0]   V_HI  [NV] = '{6'b000000, 6'b000000, 6'b010000, 6'b000000, 6'b100001};
  localparam logic [4*N-1:0] V_WGT [NV] = '{24'h111111, 24'h000013, 24'h111111, 24'h202000, 24'h100102};
  localparam int V_SEQ [NV][NG] = '{
    '{0, 1, 2, 3, 4, 5, 0, 1},   // R7 equal weights: plain rotation
    '{0, 1, 0, 0, 1, 0, 0, 0},   // R7 R8 weights 3:1 with reload
    '{4, 4, 4, 4, 4, 4, 4, 4},   // R6 high level starves low
    '{2, 3, 3, 2, 3, 3, 2, 3},   // R9 R8 weight 0 as 1, idle ch5 credit
    '{0, 5, 0, 5, 0, 0, 5, 0}    // R6 R7 weights 2:1 in high level
  };
  localparam string V_TAG [NV] = '{"R7", "R8", "R6", "R9", "R7"};

  logic           clk, rst_n, done;
  logic [N-1:0]   req, hi_prio, grant;
  logic [4*N-1:0] weight;
  int checks, fails;

  bw_share_arb #(.N_CH(N)) u_bw_share_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .hi_prio(hi_prio),
    .weight(weight), .done(done), .grant(grant)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    done  = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int idx_of(input logic [N-1:0] g);
    for (int i = 0; i < N; i++) if (g[i]) return i;
    return -1;
  endfunction

  // wait for a grant, return its index, then end the tenure
  task automatic take_grant(output int idx);
    idx = -1;
    for (int w = 0; w < 20; w++) begin
      @(negedge clk);
      if (grant != '0) begin
        idx = idx_of(grant);
        break;
      end
    end
    check("R2", $countones(grant) <= 1, $countones(grant), 1);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    check("R5", grant == '0, int'(grant), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    checks = 0;
    fails  = 0;
    req    = '0;
    hi_prio = '0;
    weight = '0;
    done   = 1'b0;
    rst_n  = 1'b0;
    #1;
    check("R1", grant == '0, int'(grant), 0);
    do_reset();

    // vector table
    for (int v = 0; v < NV; v++) begin
      req     = V_REQ[v];
      hi_prio = V_HI[v];
      weight  = V_WGT[v];
      do_reset();
      for (int k = 0; k < NG; k++) begin
        int g;
        take_grant(g);
        check(V_TAG[v], g == V_SEQ[v][k], g, V_SEQ[v][k]);
      end
      req = '0;
      do_reset();
    end

    // R1: reset right after release
    @(negedge clk);
    check("R1", grant == '0, int'(grant), 0);

    // R10: idle with a stray done pulse
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", grant == '0, int'(grant), 0);

    // R4 / R3 / R6: hold while requests change, then move to high level
    weight  = 24'h111111;
    hi_prio = 6'b010000;
    req     = 6'b000010;
    @(negedge clk);
    check("R3", grant == 6'b000010, int'(grant), 2);
    req = 6'b010000;
    repeat (3) @(negedge clk);
    check("R4", grant == 6'b000010, int'(grant), 2);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    check("R5", grant == '0, int'(grant), 0);
    @(negedge clk);
    check("R6", grant == 6'b010000, int'(grant), 16);

    // R1: reset during a held grant
    rst_n = 1'b0;
    #1;
    check("R1", grant == '0, int'(grant), 0);
    @(negedge clk);
    req = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", grant == '0, int'(grant), 0);

    summary();
  end
endmodule